// File: doc/BRIEF.md
# Vector Tail-Fill Byte Mask Generator

This unit sits beside the write-back stage of a vector load/store datapath. After a vector memory access has finished, it works out which bytes of the destination register group count as tail bytes. Under a tail-agnostic policy these bytes are overwritten with all ones. The unit takes one request per cycle. One clock later it presents a byte-enable vector that covers eight architectural registers, and next to it a fill-data bus that carries 8'hFF in every enabled byte lane.

Segment accesses are handled field by field. Each field owns `max_elems` element slots. The slots from the active length up to `max_elems` are tail. A segment access with a fractional register multiplier does not end on a register boundary. For such an access the fill also runs from the end of the last field up to the next whole-register boundary. The enable for the fill depends on the kind of access. Mask unit-stride accesses are always tail-agnostic when the all-ones fill option is configured. Every other access also needs its own tail-policy bit.

Top module: `tailfill_mask_top`

## Requirements
- R1: While `rst` is high and in the first cycle after reset, `out_valid` is 0 and `byte_en` is all zeros.
- R2: A request with `in_valid` high produces its result in `byte_en` with `out_valid` high one clock later. In a cycle without a request, `out_valid` drops to 0 and `byte_en` keeps its previous value.
- R3: The element size in bytes is 1 << `sew_exp`. For each field k in 0..F-1, where F is the field count, bytes from (k*max_elems + L)*esz up to but not including (k*max_elems + max_elems)*esz are enabled. L is the active length.
- R4: When `total_elems` is nonzero and F*max_elems is not a multiple of it, bytes from F*max_elems*esz up to the next multiple of the register byte width (VLEN/8) are also enabled.
- R5: For access kinds 0 (unit-stride), 1 (strided), 2 (indexed) and 3 (fault-only-first), filling happens only when both `tail_agn` and `cfg_ones` are 1. Otherwise `byte_en` is all zeros.
- R6: For access kind 4 (mask unit-stride), the field count is forced to 1 and `nf` is ignored. Filling depends on `cfg_ones` alone, and `tail_agn` is ignored.
- R7: Kinds 0 and 4 use `evl` as the active length L. Kinds 1, 2 and 3 use `vl`.
- R8: A field whose L is greater than or equal to `max_elems` contributes no bytes. An empty or inverted range enables nothing. No byte at or beyond 8*VLEN/8 exists in the output.
- R9: Byte lane i of `fill_data` is 8'hFF when `byte_en[i]` is 1 and 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| kind | input | 3 | Access kind code (0 unit, 1 strided, 2 indexed, 3 fault-first, 4 mask unit) |
| vl | input | CNT_W | Vector length |
| evl | input | CNT_W | Effective length for unit-stride kinds |
| sew_exp | input | 2 | Element-size exponent |
| nf | input | 4 | Field count, 1 to 8 |
| max_elems | input | CNT_W | Element slots per field |
| total_elems | input | CNT_W | Elements per whole register group |
| tail_agn | input | 1 | Instruction tail-agnostic policy bit |
| cfg_ones | input | 1 | Configuration: all-ones tail fill enabled |
| out_valid | output | 1 | Result strobe |
| byte_en | output | GROUP_BYTES | Tail byte enables |
| fill_data | output | 8*GROUP_BYTES | Fill bytes, 8'hFF on enabled lanes |

## Verification
Per-field tail ranges and the boundary extension for a fractional multiplier can both fire for the same request. The last field's tail then joins directly onto the extension region. The bench provokes this by sweeping every field count against multipliers of 1/4 and 1/2 at every element size, with lengths of zero, half, one short and full. Each result is judged against a byte-by-byte model that adds the two regions separately. A scoreboard pops one expected mask per result and compares the whole vector and the fill bus.

// File: rtl/tailfill_pkg.sv
package tailfill_pkg;

    localparam int IDX_W = 16;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [2:0] {
        ACC_UNIT        = 3'd0,
        ACC_STRIDED     = 3'd1,
        ACC_INDEXED     = 3'd2,
        ACC_FAULT_FIRST = 3'd3,
        ACC_MASK_UNIT   = 3'd4
    } acc_kind_e;

    // Resolved request after policy gating
    typedef struct packed {
        logic       fill_en;
        idx_t       len;
        logic [3:0] fields;
    } gate_t;

    // Half-open byte range [lo, hi)
    typedef struct packed {
        logic act;
        idx_t lo;
        idx_t hi;
    } span_t;

    function automatic idx_t elems_to_bytes(idx_t elems, logic [1:0] sew);
        return elems << sew;
    endfunction

    function automatic idx_t round_up_reg(idx_t b, idx_t reg_bytes);
        return (b + reg_bytes - idx_t'(1)) & ~(reg_bytes - idx_t'(1));
    endfunction

    function automatic logic in_span(span_t s, idx_t b);
        return s.act && (b >= s.lo) && (b < s.hi);
    endfunction

endpackage

// File: rtl/tf_policy_gate.sv
module tf_policy_gate
    import tailfill_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NF_MAX = 8
) (
    input  logic [2:0]       kind,
    input  logic [CNT_W-1:0] vl,
    input  logic [CNT_W-1:0] evl,
    input  logic [3:0]       nf,
    input  logic             tail_agn,
    input  logic             cfg_ones,
    output gate_t            gate
);
    acc_kind_e k;
    logic      unit_like;
    logic      mask_acc;

    always_comb begin
        k         = acc_kind_e'(kind);
        mask_acc  = (k == ACC_MASK_UNIT);
        unit_like = (k == ACC_UNIT) || mask_acc;

        gate.fill_en = mask_acc ? cfg_ones : (tail_agn && cfg_ones);
        gate.len     = unit_like ? idx_t'(evl) : idx_t'(vl);
        if (mask_acc)
            gate.fields = 4'd1;
        else if (nf > 4'(NF_MAX))
            gate.fields = 4'(NF_MAX);
        else
            gate.fields = nf;
    end
endmodule

// File: rtl/tf_span_calc.sv
module tf_span_calc
    import tailfill_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NF_MAX = 8,
    parameter int VLENB  = 16
) (
    input  gate_t              gate,
    input  logic [1:0]         sew_exp,
    input  logic [CNT_W-1:0]   max_elems,
    input  logic [CNT_W-1:0]   total_elems,
    output span_t [NF_MAX:0]   spans
);
    localparam idx_t REG_BYTES = idx_t'(VLENB);

    idx_t me_x;
    idx_t tot_x;
    assign me_x  = idx_t'(max_elems);
    assign tot_x = idx_t'(total_elems);

    // One span per segment field
    for (genvar k = 0; k < NF_MAX; k++) begin : g_field
        idx_t base;
        always_comb begin
            base         = idx_t'(k) * me_x;
            spans[k].act = gate.fill_en && (4'(k) < gate.fields);
            spans[k].lo  = elems_to_bytes(base + gate.len, sew_exp);
            spans[k].hi  = elems_to_bytes(base + me_x, sew_exp);
        end
    end

    // Partial last register of a fractional segment group
    idx_t prod;
    idx_t ext_lo;
    logic partial;
    always_comb begin
        prod    = idx_t'(gate.fields) * me_x;
        partial = (tot_x != '0) && ((prod % tot_x) != '0);
        ext_lo  = elems_to_bytes(prod, sew_exp);
        spans[NF_MAX].act = gate.fill_en && partial;
        spans[NF_MAX].lo  = ext_lo;
        spans[NF_MAX].hi  = round_up_reg(ext_lo, REG_BYTES);
    end
endmodule

// File: rtl/tf_byte_mask.sv
module tf_byte_mask
    import tailfill_pkg::*;
#(
    parameter int GROUP_BYTES = 128,
    parameter int NSPAN       = 9
) (
    input  span_t [NSPAN-1:0]      spans,
    output logic [GROUP_BYTES-1:0] mask
);
    for (genvar b = 0; b < GROUP_BYTES; b++) begin : g_byte
        always_comb begin
            mask[b] = 1'b0;
            for (int s = 0; s < NSPAN; s++)
                if (in_span(spans[s], idx_t'(b)))
                    mask[b] = 1'b1;
        end
    end
endmodule

// File: rtl/tailfill_mask_top.sv
module tailfill_mask_top
    import tailfill_pkg::*;
#(
    parameter int VLEN        = 128,
    parameter int NF_MAX      = 8,
    parameter int VLENB       = VLEN / 8,
    parameter int GROUP_BYTES = 8 * VLENB,
    parameter int CNT_W       = $clog2(GROUP_BYTES) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [2:0]               kind,
    input  logic [CNT_W-1:0]         vl,
    input  logic [CNT_W-1:0]         evl,
    input  logic [1:0]               sew_exp,
    input  logic [3:0]               nf,
    input  logic [CNT_W-1:0]         max_elems,
    input  logic [CNT_W-1:0]         total_elems,
    input  logic                     tail_agn,
    input  logic                     cfg_ones,
    output logic                     out_valid,
    output logic [GROUP_BYTES-1:0]   byte_en,
    output logic [8*GROUP_BYTES-1:0] fill_data
);
    localparam int NSPAN = NF_MAX + 1;

    gate_t               gate;
    span_t [NSPAN-1:0]   spans;
    logic [GROUP_BYTES-1:0] mask_next;

    tf_policy_gate #(.CNT_W(CNT_W), .NF_MAX(NF_MAX)) u_gate (
        .kind(kind), .vl(vl), .evl(evl), .nf(nf),
        .tail_agn(tail_agn), .cfg_ones(cfg_ones), .gate(gate)
    );

    tf_span_calc #(.CNT_W(CNT_W), .NF_MAX(NF_MAX), .VLENB(VLENB)) u_span (
        .gate(gate), .sew_exp(sew_exp), .max_elems(max_elems),
        .total_elems(total_elems), .spans(spans)
    );

    tf_byte_mask #(.GROUP_BYTES(GROUP_BYTES), .NSPAN(NSPAN)) u_mask (
        .spans(spans), .mask(mask_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            byte_en   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                byte_en <= mask_next;
        end
    end

    for (genvar i = 0; i < GROUP_BYTES; i++) begin : g_fill
        assign fill_data[8*i +: 8] = {8{byte_en[i]}};
    end
endmodule

// File: rtl/tailfill_mask_chk.sv
module tailfill_mask_chk #(
    parameter int GROUP_BYTES = 128,
    parameter int CNT_W       = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [2:0]             kind,
    input logic [CNT_W-1:0]       vl,
    input logic [CNT_W-1:0]       evl,
    input logic [3:0]             nf,
    input logic [CNT_W-1:0]       max_elems,
    input logic [CNT_W-1:0]       total_elems,
    input logic                   tail_agn,
    input logic                   cfg_ones,
    input logic                   out_valid,
    input logic [GROUP_BYTES-1:0] byte_en
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(byte_en)));

    p_cfg_off_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg_ones) |=> (byte_en == '0));

    p_policy_off_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind != 3'd4 && !tail_agn) |=> (byte_en == '0));

    p_mask_ignores_policy_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == 3'd4 && cfg_ones && !tail_agn && evl == '0 && max_elems != '0)
        |=> byte_en[0]);

    p_first_byte_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == 3'd1 && tail_agn && cfg_ones && vl == '0 && max_elems != '0 && nf != 4'd0)
        |=> byte_en[0]);

    p_full_field_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == 3'd1 && nf == 4'd1 && vl >= max_elems && max_elems == total_elems)
        |=> (byte_en == '0));
endmodule

bind tailfill_mask_top tailfill_mask_chk #(
    .GROUP_BYTES(GROUP_BYTES), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .vl(vl), .evl(evl),
    .nf(nf), .max_elems(max_elems), .total_elems(total_elems), .tail_agn(tail_agn),
    .cfg_ones(cfg_ones), .out_valid(out_valid), .byte_en(byte_en)
);

// File: tb/tailfill_mask_top_tb.sv
module tailfill_mask_top_tb;
    localparam int VLENB = 16;
    localparam int GB    = 8 * VLENB;
    localparam int CW    = $clog2(GB) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [2:0]    kind = '0;
    logic [CW-1:0] vl = '0, evl = '0, max_elems = '0, total_elems = '0;
    logic [1:0]    sew_exp = '0;
    logic [3:0]    nf = 4'd1;
    logic          tail_agn = 1'b0, cfg_ones = 1'b0;
    logic          out_valid;
    logic [GB-1:0] byte_en;
    logic [8*GB-1:0] fill_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [GB-1:0] exp_q[$];
    string         tag_q[$];
    logic [GB-1:0] last_exp = '0;

    always #4 clk = ~clk;

    tailfill_mask_top #(.VLEN(8*VLENB)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .vl(vl), .evl(evl),
        .sew_exp(sew_exp), .nf(nf), .max_elems(max_elems), .total_elems(total_elems),
        .tail_agn(tail_agn), .cfg_ones(cfg_ones), .out_valid(out_valid),
        .byte_en(byte_en), .fill_data(fill_data)
    );

    function automatic logic [GB-1:0] ref_mask(int k, int l_vl, int l_evl, int sew,
                                               int f, int me, int tot, bit pol, bit cfg);
        logic [GB-1:0] m = '0;
        int len, n, esz, lo, hi;
        if (!((k == 4) ? cfg : (pol && cfg))) return m;
        len = (k == 0 || k == 4) ? l_evl : l_vl;
        n   = (k == 4) ? 1 : f;
        esz = 1 << sew;
        for (int fi = 0; fi < n; fi++)
            for (int b = (fi*me + len)*esz; b < (fi*me + me)*esz && b < GB; b++)
                m[b] = 1'b1;
        if (tot != 0 && ((n*me) % tot) != 0) begin
            lo = n*me*esz;
            hi = ((lo + VLENB - 1) / VLENB) * VLENB;
            for (int b = lo; b < hi && b < GB; b++) m[b] = 1'b1;
        end
        return m;
    endfunction

    task automatic check(bit ok, string tag, logic [GB-1:0] act, logic [GB-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(int k, int l_vl, int l_evl, int sew, int f, int me, int tot,
                        bit pol, bit cfg, string tag);
        @(negedge clk);
        in_valid = 1'b1; kind = 3'(k); vl = CW'(l_vl); evl = CW'(l_evl);
        sew_exp = 2'(sew); nf = 4'(f); max_elems = CW'(me); total_elems = CW'(tot);
        tail_agn = pol; cfg_ones = cfg;
        exp_q.push_back(ref_mask(k, l_vl, l_evl, sew, f, me, tot, pol, cfg));
        tag_q.push_back(tag);
    endtask

    // Monitor: one expected item per result strobe
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            logic [GB-1:0] e;
            logic [8*GB-1:0] ef;
            string t;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", byte_en, '0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check(byte_en === e, t, byte_en, e);
                for (int i = 0; i < GB; i++) ef[8*i +: 8] = e[i] ? 8'hFF : 8'h00;
                n_tests++;
                if (fill_data !== ef) begin
                    n_fail++;
                    $display("FAIL R9 fill actual=%h expected=%h", fill_data, ef);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && byte_en === '0, "R1 during reset", byte_en, '0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0 && byte_en === '0, "R1 after reset", byte_en, '0);

        // Sweep: element sizes, multipliers 1/4..8, all legal field counts
        for (int sew = 0; sew < 4; sew++) begin
            for (int lm = -2; lm <= 3; lm++) begin
                for (int f = 1; f <= 8; f++) begin
                    int me, tot, regs;
                    regs = (lm > 0) ? (1 << lm) : 1;
                    if (lm > 0 && f * regs > 8) continue;
                    me  = (lm >= 0) ? ((VLENB << lm) >> sew) : ((VLENB >> (-lm)) >> sew);
                    tot = (VLENB * regs) >> sew;
                    if (me == 0) continue;
                    for (int vi = 0; vi < 4; vi++) begin
                        int v;
                        string tg;
                        v = (vi == 0) ? 0 : (vi == 1) ? me/2 : (vi == 2) ? me-1 : me;
                        if (v >= me) tg = "R8 full field";
                        else if (lm < 0 && f > 1) tg = "R4 fractional segment";
                        else tg = "R3 field tail";
                        send(1 + (vi % 3), v, 0, sew, f, me, tot, 1'b1, 1'b1, tg);
                    end
                end
            end
        end

        // R7: unit-stride uses evl, strided uses vl
        send(0, 2, 5, 0, 2, 8, 16, 1'b1, 1'b1, "R7 unit uses evl");
        send(1, 2, 5, 0, 2, 8, 16, 1'b1, 1'b1, "R7 strided uses vl");
        send(3, 3, 0, 1, 1, 8, 8, 1'b1, 1'b1, "R7 fault-first uses vl");
        // R5: policy gating
        send(2, 1, 1, 0, 1, 16, 16, 1'b0, 1'b1, "R5 policy off");
        send(2, 1, 1, 0, 1, 16, 16, 1'b1, 1'b0, "R5 config off");
        // R6: mask kind ignores policy and nf
        send(4, 0, 3, 0, 5, 16, 16, 1'b0, 1'b1, "R6 mask always agnostic");
        send(4, 0, 3, 0, 5, 16, 16, 1'b1, 1'b0, "R6 mask config off");
        // R4: half-register single field
        send(1, 1, 0, 2, 1, 2, 4, 1'b1, 1'b1, "R4 fractional single");
        // R8: length past max_elems
        send(1, 100, 0, 0, 3, 16, 16, 1'b1, 1'b1, "R8 length beyond field");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results seen", '0, '0);
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && byte_en === last_exp, "R2 hold when idle", byte_en, last_exp);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule